// File: doc/BRIEF.md
# Memory-Type-Aware Cache Policy Controller

This block is a small direct-mapped data cache controller that sits between a processor load/store port and a simple word-wide memory bus. Every request carries a 3-bit memory-type tag. That tag decides at run time how the access treats the cache. It can bypass the cache entirely, write through to memory, write back lazily, or write to memory while throwing the cached copy away. One cache can therefore hold ordinary data and also serve device or frame-buffer regions without a second controller.

The cache holds `LINES` lines of `WORDS` words. The bus moves one word per handshake: a line fill takes `WORDS` read beats and a line write-back takes `WORDS` write beats. A flush input drains all modified lines to memory and empties the cache. The processor port handles one request at a time. A request is accepted on `cpu_valid && cpu_ready`, and its completion is a one-cycle `cpu_done` pulse that carries read data.

Top module: `mtype_cache_ctrl`

## Requirements
- R1: After reset `cpu_ready` is high, and `bus_valid`, `cpu_done` and `flush_done` are low.
- R2: Type code 6 selects write-back, 4 selects write-through, 5 selects write-protect and 1 selects write-combine. Code 0 and every other code (2, 3, 7) behave as uncached.
- R3: An uncached access performs exactly one bus beat at its own address with the request's direction. It never answers from the line and never allocates one, so repeating it costs another bus beat.
- R4: A write-combine access performs exactly one bus beat and never allocates a line.
- R5: Under write-through, write-protect or write-back, a read hit returns the line's word with no bus traffic. A read miss fills the whole line with `WORDS` read beats at word offsets in ascending order, then returns the requested word.
- R6: A write-through write performs exactly one bus write. On a hit it also updates the cached word. On a miss no line is allocated, so a later read of that line misses.
- R7: A write-back write miss fills the line and then writes only into the cache, leaving memory unchanged. A write-back write hit causes no bus traffic. Both leave the line modified.
- R8: A miss that must reuse a slot holding a modified line of another tag first writes back that line's `WORDS` words in ascending offset order, and only then starts the fill.
- R9: A write-protect write performs one bus write and invalidates a matching line. If that line is modified, it is written back before the single write.
- R10: An uncached access that hits a cached line invalidates it. A modified line is written back before the single bus beat.
- R11: A flush writes back every modified line, invalidates all lines and then raises `flush_done` for exactly one cycle. After the flush, memory holds all data written so far.
- R12: When `flush_req` and a processor request arrive in the same idle cycle, the flush runs to completion first. The request is accepted afterwards.
- R13: `bus_valid`, once raised, stays high with stable address, direction and write data until `bus_ready`. After a processor request is accepted, `cpu_ready` stays low until that request completes.
- R14: Byte enable bit i selects bits 8i+7..8i of the word. Only enabled bytes change, both in memory and in the cached line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_ready | output | 1 | Controller can accept a request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_be | input | DATA_W/8 | Store byte enables |
| cpu_mtype | input | 3 | Memory-type code of the request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_done` |
| flush_req | input | 1 | Request to drain and empty the cache |
| flush_done | output | 1 | One-cycle pulse when the flush is finished |
| bus_valid | output | 1 | Bus beat requested |
| bus_ready | input | 1 | Bus beat completes this cycle |
| bus_we | output | 1 | Bus beat direction, 1 = write |
| bus_addr | output | ADDR_W | Bus word address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_be | output | DATA_W/8 | Bus write byte enables |
| bus_rdata | input | DATA_W | Bus read data, valid with `bus_ready` |

## Verification
A flush request and a processor request can both arrive in the same idle cycle. The bench raises `flush_req` and `cpu_valid` on the same clock edge while a modified line holds the address that the load targets. It then judges the order of the two completions and the bus log. The flush must report done before the load. The log must show the line's write-back first, followed by a fresh fill for the load, because the flush invalidated the line. A second overlap is the modified-line write-back that runs before an uncached or write-protect single beat. For that case the bench checks that the write-back beats come first and the single beat last.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

  typedef enum logic [2:0] {MT_UC, MT_WC, MT_WT, MT_WP, MT_WB} mtype_e;

  typedef enum logic [1:0] {TOP_NONE, TOP_FILL, TOP_INVAL, TOP_DIRTY} tag_op_e;

  typedef enum logic [1:0] {NX_FILL, NX_SGL, NX_FLUSH} next_e;

  // Unlisted codes fall back to the uncached behaviour.
  function automatic mtype_e decode_mtype(input logic [2:0] code);
    case (code)
      3'd1:    return MT_WC;
      3'd4:    return MT_WT;
      3'd5:    return MT_WP;
      3'd6:    return MT_WB;
      default: return MT_UC;
    endcase
  endfunction

endpackage

// File: rtl/mtc_tag_store.sv
module mtc_tag_store
  import mtc_pkg::*;
#(
  parameter int LINES = 16,
  parameter int TAG_W = 6,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  tag_op_e          op,
  input  logic [TAG_W-1:0] wtag,
  output logic             valid,
  output logic             dirty,
  output logic [TAG_W-1:0] tag
);

  logic [LINES-1:0] v_q, d_q;
  logic [TAG_W-1:0] t_q [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= '0;
      d_q <= '0;
    end else begin
      case (op)
        TOP_FILL:  begin v_q[idx] <= 1'b1; d_q[idx] <= 1'b0; end
        TOP_INVAL: begin v_q[idx] <= 1'b0; d_q[idx] <= 1'b0; end
        TOP_DIRTY: d_q[idx] <= 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (op == TOP_FILL) t_q[idx] <= wtag;
  end

  assign valid = v_q[idx];
  assign dirty = d_q[idx];
  assign tag   = t_q[idx];

endmodule

// File: rtl/mtc_line_ram.sv
module mtc_line_ram #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int NB = DATA_W / 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [NB-1:0]     be,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (we && be[b]) mem[addr][8*b +: 8] <= wdata[8*b +: 8];
    end
    q <= mem[addr];
  end

endmodule

// File: rtl/mtype_cache_ctrl.sv
module mtype_cache_ctrl
  import mtc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int WORDS  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cpu_valid,
  output logic                cpu_ready,
  input  logic                cpu_we,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [DATA_W-1:0]   cpu_wdata,
  input  logic [DATA_W/8-1:0] cpu_be,
  input  logic [2:0]          cpu_mtype,
  output logic                cpu_done,
  output logic [DATA_W-1:0]   cpu_rdata,
  input  logic                flush_req,
  output logic                flush_done,
  output logic                bus_valid,
  input  logic                bus_ready,
  output logic                bus_we,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0]   bus_rdata
);

  localparam int OFF_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int NB    = DATA_W / 8;

  typedef enum logic [3:0] {
    S_IDLE, S_LOOK, S_EV_RD, S_EV_LD, S_EV_WR,
    S_FILL_GO, S_FILL, S_FIN, S_SGL_GO, S_SGL, S_FL_SCAN
  } state_e;

  state_e            st;
  next_e             nx;
  mtype_e            req_mt;
  logic              req_we;
  logic [TAG_W-1:0]  req_tag;
  logic [OFF_W-1:0]  req_off, cnt;
  logic [IDX_W-1:0]  line;
  logic [DATA_W-1:0] req_wdata;
  logic [NB-1:0]     req_be;

  logic              ln_valid, ln_dirty, hit, drop, cacheable_wr;
  logic [TAG_W-1:0]  ln_tag;
  tag_op_e           tag_op;

  logic                    ram_we;
  logic [NB-1:0]           ram_be;
  logic [DATA_W-1:0]       ram_wdata, ram_q;
  logic [IDX_W+OFF_W-1:0]  ram_addr;

  assign cpu_ready    = (st == S_IDLE) && !flush_req;
  assign hit          = ln_valid && (ln_tag == req_tag);
  // Uncached access, or a store to a write-protect region, drops the line.
  assign drop         = (req_mt == MT_UC) || (req_mt == MT_WP && req_we);
  assign cacheable_wr = (req_mt == MT_WT) || (req_mt == MT_WB);

  mtc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) i_tags (
    .clk(clk), .rst(rst), .idx(line), .op(tag_op), .wtag(req_tag),
    .valid(ln_valid), .dirty(ln_dirty), .tag(ln_tag)
  );

  mtc_line_ram #(.DEPTH(LINES * WORDS), .DATA_W(DATA_W)) i_ram (
    .clk(clk), .we(ram_we), .be(ram_be), .addr(ram_addr),
    .wdata(ram_wdata), .q(ram_q)
  );

  always_comb begin
    case (st)
      S_IDLE:                               ram_addr = cpu_addr[IDX_W+OFF_W-1:0];
      S_EV_RD, S_EV_LD, S_EV_WR,
      S_FILL_GO, S_FILL:                    ram_addr = {line, cnt};
      default:                              ram_addr = {line, req_off};
    endcase
    ram_we    = 1'b0;
    ram_be    = req_be;
    ram_wdata = req_wdata;
    tag_op    = TOP_NONE;
    case (st)
      S_LOOK: begin
        if (req_mt != MT_WC) begin
          if (drop) begin
            if (hit && !ln_dirty) tag_op = TOP_INVAL;
          end else if (hit && req_we && cacheable_wr) begin
            ram_we = 1'b1;
            if (req_mt == MT_WB) tag_op = TOP_DIRTY;
          end
        end
      end
      S_EV_WR:   if (bus_ready && (&cnt)) tag_op = TOP_INVAL;
      S_FILL: begin
        if (bus_ready) begin
          ram_we    = 1'b1;
          ram_be    = '1;
          ram_wdata = bus_rdata;
          if (&cnt) tag_op = TOP_FILL;
        end
      end
      S_FIN: begin
        if (req_we) begin
          ram_we = 1'b1;
          tag_op = TOP_DIRTY;
        end
      end
      S_FL_SCAN: if (!(ln_valid && ln_dirty)) tag_op = TOP_INVAL;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      nx         <= NX_FILL;
      cnt        <= '0;
      line       <= '0;
      req_mt     <= MT_UC;
      req_we     <= 1'b0;
      req_tag    <= '0;
      req_off    <= '0;
      req_wdata  <= '0;
      req_be     <= '0;
      cpu_done   <= 1'b0;
      cpu_rdata  <= '0;
      flush_done <= 1'b0;
      bus_valid  <= 1'b0;
      bus_we     <= 1'b0;
      bus_addr   <= '0;
      bus_wdata  <= '0;
      bus_be     <= '0;
    end else begin
      cpu_done   <= 1'b0;
      flush_done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (flush_req) begin
            line <= '0;
            st   <= S_FL_SCAN;
          end else if (cpu_valid) begin
            req_mt    <= decode_mtype(cpu_mtype);
            req_we    <= cpu_we;
            req_tag   <= cpu_addr[ADDR_W-1 -: TAG_W];
            line      <= cpu_addr[OFF_W +: IDX_W];
            req_off   <= cpu_addr[OFF_W-1:0];
            req_wdata <= cpu_wdata;
            req_be    <= cpu_be;
            st        <= S_LOOK;
          end
        end
        S_LOOK: begin
          cnt <= '0;
          if (req_mt == MT_WC) st <= S_SGL_GO;
          else if (drop) begin
            if (hit && ln_dirty) begin nx <= NX_SGL; st <= S_EV_RD; end
            else st <= S_SGL_GO;
          end else if (hit) begin
            if (!req_we) begin
              cpu_rdata <= ram_q;
              cpu_done  <= 1'b1;
              st        <= S_IDLE;
            end else if (req_mt == MT_WT) st <= S_SGL_GO;
            else begin
              cpu_done <= 1'b1;
              st       <= S_IDLE;
            end
          end else if (req_we && req_mt == MT_WT) st <= S_SGL_GO;
          else begin
            nx <= NX_FILL;
            st <= (ln_valid && ln_dirty) ? S_EV_RD : S_FILL_GO;
          end
        end
        S_EV_RD: st <= S_EV_LD;
        S_EV_LD: begin
          bus_valid <= 1'b1;
          bus_we    <= 1'b1;
          bus_addr  <= {ln_tag, line, cnt};
          bus_wdata <= ram_q;
          bus_be    <= '1;
          st        <= S_EV_WR;
        end
        S_EV_WR: begin
          if (bus_ready) begin
            bus_valid <= 1'b0;
            cnt       <= cnt + 1'b1;
            if (&cnt) begin
              case (nx)
                NX_FILL:  st <= S_FILL_GO;
                NX_SGL:   st <= S_SGL_GO;
                default:  st <= S_FL_SCAN;
              endcase
            end else st <= S_EV_RD;
          end
        end
        S_FILL_GO: begin
          bus_valid <= 1'b1;
          bus_we    <= 1'b0;
          bus_addr  <= {req_tag, line, cnt};
          bus_be    <= '1;
          st        <= S_FILL;
        end
        S_FILL: begin
          if (bus_ready) begin
            bus_valid <= 1'b0;
            if (cnt == req_off) cpu_rdata <= bus_rdata;
            cnt <= cnt + 1'b1;
            st  <= (&cnt) ? S_FIN : S_FILL_GO;
          end
        end
        S_FIN: begin
          cpu_done <= 1'b1;
          st       <= S_IDLE;
        end
        S_SGL_GO: begin
          bus_valid <= 1'b1;
          bus_we    <= req_we;
          bus_addr  <= {req_tag, line, req_off};
          bus_wdata <= req_wdata;
          bus_be    <= req_we ? req_be : '1;
          st        <= S_SGL;
        end
        S_SGL: begin
          if (bus_ready) begin
            bus_valid <= 1'b0;
            if (!req_we) cpu_rdata <= bus_rdata;
            cpu_done <= 1'b1;
            st       <= S_IDLE;
          end
        end
        S_FL_SCAN: begin
          cnt <= '0;
          if (ln_valid && ln_dirty) begin
            nx <= NX_FLUSH;
            st <= S_EV_RD;
          end else if (&line) begin
            flush_done <= 1'b1;
            st         <= S_IDLE;
          end else line <= line + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mtc_checker.sv
module mtc_checker
  import mtc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_valid,
  input logic              cpu_ready,
  input logic [2:0]        cpu_mtype,
  input logic              cpu_done,
  input logic              flush_done,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata
);

  logic acc_uc;
  assign acc_uc = cpu_valid && cpu_ready && (decode_mtype(cpu_mtype) == MT_UC);

  a_r13_bus_hold: assert property (@(posedge clk) disable iff (rst)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  a_r13_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    cpu_valid && cpu_ready |=> !cpu_ready);

  // R3: the earliest answer an uncached access could take from the line never appears.
  a_r3_uc_not_from_line: assert property (@(posedge clk) disable iff (rst)
    acc_uc |-> ##2 !cpu_done);

  a_r11_flush_pulse: assert property (@(posedge clk) disable iff (rst)
    flush_done |=> !flush_done);

  a_r12_flush_apart: assert property (@(posedge clk) disable iff (rst)
    flush_done |-> !cpu_done);

endmodule

bind mtype_cache_ctrl mtc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
  .cpu_mtype(cpu_mtype), .cpu_done(cpu_done), .flush_done(flush_done),
  .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/test_mtype_cache_ctrl.sv
module test_mtype_cache_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int MEMN = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_valid = 1'b0, cpu_we = 1'b0, flush_req = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [3:0] cpu_be = '0;
  logic [2:0] cpu_mtype = '0;
  logic cpu_ready, cpu_done, flush_done;
  logic [31:0] cpu_rdata;
  logic bus_valid, bus_we;
  logic bus_ready = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic [3:0] bus_be;

  always #(CLK_PERIOD/2) clk = ~clk;

  mtype_cache_ctrl #(.ADDR_W(AW), .DATA_W(32), .LINES(16), .WORDS(4)) i_mtype_cache_ctrl (
    .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_mtype(cpu_mtype),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .flush_req(flush_req), .flush_done(flush_done),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata)
  );

  // Memory model and bus log
  logic [31:0] mem [MEMN];
  logic [31:0] sh  [MEMN];
  logic        lg_we [4096];
  logic [AW-1:0] lg_a [4096];
  int rd_n = 0, wr_n = 0, lg_n = 0;
  bit init_done = 0;
  int total = 0, bad = 0;

  function automatic logic [31:0] init_val(input int i);
    return (i * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
    return r;
  endfunction

  function automatic logic [AW-1:0] mk(input int t, input int i, input int o);
    return {t[5:0], i[3:0], o[1:0]};
  endfunction

  always @(negedge clk) begin
    if (rst && !init_done) begin
      for (int i = 0; i < MEMN; i++) mem[i] = init_val(i);
      init_done = 1;
    end
    if (bus_ready) bus_ready = 1'b0;
    else if (!rst && bus_valid && ($urandom_range(0, 2) == 0)) begin
      bus_ready = 1'b1;
      if (bus_we) begin
        mem[bus_addr] = merge(mem[bus_addr], bus_wdata, bus_be);
        wr_n++;
      end else begin
        bus_rdata = mem[bus_addr];
        rd_n++;
      end
      if (lg_n < 4096) begin
        lg_we[lg_n] = bus_we;
        lg_a[lg_n]  = bus_addr;
        lg_n++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  int rd0, wr0, lg0;
  logic [31:0] got;

  task automatic mark();
    rd0 = rd_n; wr0 = wr_n; lg0 = lg_n;
  endtask

  // Called at a negedge; returns at the negedge where cpu_done is seen.
  task automatic op(input logic we, input logic [AW-1:0] a, input logic [31:0] wd,
                    input logic [3:0] be, input logic [2:0] mt, input string req);
    mark();
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be; cpu_mtype = mt;
    while (!cpu_ready) @(negedge clk);
    @(negedge clk);
    cpu_valid = 1'b0;
    while (!cpu_done) @(negedge clk);
    got = cpu_rdata;
    if (we) sh[a] = merge(sh[a], wd, be);
    else chk(got == sh[a], {req, " read data"}, got, sh[a]);
  endtask

  task automatic beats(input string req, input int er, input int ew);
    chk(rd_n - rd0 == er, {req, " read beats"}, rd_n - rd0, er);
    chk(wr_n - wr0 == ew, {req, " write beats"}, wr_n - wr0, ew);
  endtask

  task automatic do_flush();
    mark();
    flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;
    while (!flush_done) @(negedge clk);
    @(negedge clk);
    chk(flush_done == 1'b0, "R11 flush_done single cycle", flush_done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit fl_seen;
    int mis;
    void'($urandom(32'h0BAD5EED));
    for (int i = 0; i < MEMN; i++) sh[i] = init_val(i);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cpu_ready == 1'b1, "R1 cpu_ready", cpu_ready, 1);
    chk(bus_valid == 1'b0, "R1 bus_valid", bus_valid, 0);
    chk(cpu_done == 1'b0 && flush_done == 1'b0, "R1 done outputs", {cpu_done, flush_done}, 0);

    // R3 uncached read, twice: one beat each, no allocation
    op(0, mk(1,0,1), 0, 4'hF, 3'd0, "R3");
    beats("R3 first", 1, 0);
    chk(lg_a[lg0] == mk(1,0,1), "R3 bus address", lg_a[lg0], mk(1,0,1));
    op(0, mk(1,0,1), 0, 4'hF, 3'd0, "R3");
    beats("R3 repeat", 1, 0);
    // R2 unlisted codes act as uncached
    op(0, mk(1,0,1), 0, 4'hF, 3'd7, "R2");
    beats("R2 code 7", 1, 0);
    op(0, mk(1,0,2), 0, 4'hF, 3'd2, "R2");
    beats("R2 code 2", 1, 0);
    op(0, mk(1,0,2), 0, 4'hF, 3'd3, "R2");
    beats("R2 code 3", 1, 0);

    // R5 write-through read miss then hit
    op(0, mk(2,1,2), 0, 4'hF, 3'd4, "R5");
    beats("R5 miss", 4, 0);
    chk(lg_a[lg0] == mk(2,1,0) && lg_a[lg0+3] == mk(2,1,3), "R5 fill order", lg_a[lg0+3], mk(2,1,3));
    op(0, mk(2,1,0), 0, 4'hF, 3'd4, "R5");
    beats("R5 hit", 0, 0);

    // R6 / R14 write-through write hit with partial enables
    op(1, mk(2,1,3), 32'hA1B2C3D4, 4'b0101, 3'd4, "R6");
    beats("R6 hit", 0, 1);
    chk(mem[mk(2,1,3)] == sh[mk(2,1,3)], "R14 memory byte merge", mem[mk(2,1,3)], sh[mk(2,1,3)]);
    op(0, mk(2,1,3), 0, 4'hF, 3'd4, "R14 line byte merge");
    beats("R6 line kept", 0, 0);
    // R6 write miss does not allocate
    op(1, mk(3,2,0), 32'h11223344, 4'hF, 3'd4, "R6");
    beats("R6 miss", 0, 1);
    op(0, mk(3,2,0), 0, 4'hF, 3'd4, "R6");
    beats("R6 no allocate", 4, 0);

    // R7 write-back write miss and hit
    op(1, mk(4,3,1), 32'hCAFEF00D, 4'hF, 3'd6, "R7");
    beats("R7 miss", 4, 0);
    chk(mem[mk(4,3,1)] == init_val(mk(4,3,1)), "R7 memory untouched", mem[mk(4,3,1)], init_val(mk(4,3,1)));
    op(1, mk(4,3,1), 32'h77000000, 4'b1000, 3'd6, "R7");
    beats("R7 hit", 0, 0);
    op(0, mk(4,3,1), 0, 4'hF, 3'd6, "R7");
    beats("R7 read hit", 0, 0);

    // R8 conflict miss evicts the modified line first
    op(0, mk(5,3,2), 0, 4'hF, 3'd6, "R8");
    beats("R8", 4, 4);
    chk(lg_we[lg0] == 1'b1 && lg_a[lg0] == mk(4,3,0), "R8 eviction first", lg_a[lg0], mk(4,3,0));
    chk(lg_a[lg0+3] == mk(4,3,3), "R8 eviction order", lg_a[lg0+3], mk(4,3,3));
    chk(lg_we[lg0+4] == 1'b0 && lg_a[lg0+4] == mk(5,3,0), "R8 fill after", lg_a[lg0+4], mk(5,3,0));
    chk(mem[mk(4,3,1)] == sh[mk(4,3,1)], "R8 written back", mem[mk(4,3,1)], sh[mk(4,3,1)]);

    // R9 write-protect
    op(0, mk(6,4,0), 0, 4'hF, 3'd5, "R9");
    beats("R9 read fill", 4, 0);
    op(1, mk(6,4,0), 32'h0F0F0F0F, 4'hF, 3'd5, "R9");
    beats("R9 write", 0, 1);
    chk(mem[mk(6,4,0)] == sh[mk(6,4,0)], "R9 memory", mem[mk(6,4,0)], sh[mk(6,4,0)]);
    op(0, mk(6,4,0), 0, 4'hF, 3'd5, "R9");
    beats("R9 invalidated", 4, 0);
    op(1, mk(7,5,0), 32'h12345678, 4'hF, 3'd6, "R9");
    op(1, mk(7,5,1), 32'h9ABCDEF0, 4'hF, 3'd5, "R9");
    beats("R9 dirty line", 0, 5);
    chk(lg_a[lg0+4] == mk(7,5,1), "R9 single write last", lg_a[lg0+4], mk(7,5,1));
    op(0, mk(7,5,0), 0, 4'hF, 3'd6, "R9");
    beats("R9 refetch", 4, 0);

    // R10 uncached access to cached lines
    op(1, mk(8,6,2), 32'hDEADBEEF, 4'hF, 3'd6, "R10");
    op(0, mk(8,6,2), 0, 4'hF, 3'd0, "R10");
    beats("R10 dirty", 1, 4);
    op(0, mk(8,6,2), 0, 4'hF, 3'd4, "R10");
    beats("R10 invalidated", 4, 0);
    op(1, mk(8,6,0), 32'h55AA55AA, 4'hF, 3'd0, "R10");
    beats("R10 clean write", 0, 1);
    op(0, mk(8,6,0), 0, 4'hF, 3'd4, "R10");
    beats("R10 clean invalidated", 4, 0);

    // R4 write-combine
    op(1, mk(40,7,0), 32'h0BADCAFE, 4'hF, 3'd1, "R4");
    beats("R4 write", 0, 1);
    chk(mem[mk(40,7,0)] == sh[mk(40,7,0)], "R4 memory", mem[mk(40,7,0)], sh[mk(40,7,0)]);
    op(0, mk(40,7,0), 0, 4'hF, 3'd1, "R4");
    beats("R4 read", 1, 0);

    // R11 flush
    op(1, mk(9,8,0), 32'h13579BDF, 4'hF, 3'd6, "R11");
    op(1, mk(10,9,3), 32'h2468ACE0, 4'hF, 3'd6, "R11");
    do_flush();
    beats("R11 flush", 0, 8);
    chk(mem[mk(10,9,3)] == sh[mk(10,9,3)], "R11 memory", mem[mk(10,9,3)], sh[mk(10,9,3)]);
    op(0, mk(9,8,0), 0, 4'hF, 3'd6, "R11");
    beats("R11 emptied", 4, 0);

    // R12 flush and request together
    op(1, mk(11,10,1), 32'hFEEDFACE, 4'hF, 3'd6, "R12");
    mark();
    fl_seen = 0;
    flush_req = 1'b1; cpu_valid = 1'b1; cpu_we = 1'b0; cpu_addr = mk(11,10,1); cpu_mtype = 3'd6; cpu_be = 4'hF;
    @(negedge clk);
    flush_req = 1'b0;
    while (!cpu_done) begin
      if (flush_done) fl_seen = 1;
      if (cpu_valid && cpu_ready) begin
        @(negedge clk);
        cpu_valid = 1'b0;
      end else @(negedge clk);
    end
    chk(fl_seen, "R12 flush finished first", fl_seen, 1);
    chk(cpu_rdata == sh[mk(11,10,1)], "R12 read data", cpu_rdata, sh[mk(11,10,1)]);
    beats("R12", 4, 4);
    chk(lg_we[lg0] == 1'b1 && lg_we[lg0+4] == 1'b0, "R12 order", {lg_we[lg0], lg_we[lg0+4]}, 2'b10);

    // Random mix over a cacheable region, R5 R6 R7 R8 R9 R10 data checks
    for (int k = 0; k < 300; k++) begin
      logic [2:0] codes [7] = '{3'd0, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
      logic [2:0] mt = codes[$urandom_range(0, 6)];
      logic [AW-1:0] a = mk(12 + $urandom_range(0, 3), $urandom_range(0, 15), $urandom_range(0, 3));
      logic w = $urandom_range(0, 1) == 1;
      op(w, a, $urandom, 4'($urandom_range(1, 15)), mt, "R5 random mix");
    end
    do_flush();
    mis = 0;
    for (int i = 0; i < MEMN; i++) if (mem[i] !== sh[i]) mis++;
    chk(mis == 0, "R11 memory equals written data after flush", mis, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule